// File: doc/BRIEF.md
# Debug Pipeline Word Injector

This block is a small JTAG master that hands one 32-bit instruction or data word to a processor halted in debug state. A host supplies the word and a speed flag with a single-cycle request. The block then drives TCK, TMS and TDI itself. It loads the scan-select instruction and picks scan chain 1. It loads the internal-test instruction. It shifts the speed flag and then the word into the data register. Finally it walks the TAP through Update-DR into Run-Test/Idle. That idle visit supplies the debug clock that moves the word into the target pipeline.

The chain selection never passes through Run-Test/Idle, because an idle visit there would clock the halted core too early. The bits read on TDO while the word shifts are returned to the host. Two saturating counters record how many words went out with the flag set and how many with it clear.

When the block leaves reset, the TAP is assumed to be parked in Run-Test/Idle. While idle, the block holds TCK and TMS low.

Top module: `dbg_pipe_inject`

## Requirements
- R1: After reset, busy_o, done_o, tck_o, tms_o, tdi_o, rdata_o and both counters are 0.
- R2: An accepted request first shifts IR code 4'b0010 into the instruction register, LSB first. It then shifts chain number 4'b0001 into the data register, LSB first. It then shifts IR code 4'b1100. Run-Test/Idle is not entered before the final word has been updated.
- R3: In the data scan of chain 1, the first TDI bit is sysspd_i (1 = system speed, 0 = debug speed), followed by the 32 word bits with bit 31 first.
- R4: After the last word bit the TAP goes Exit1-DR, Update-DR, Run-Test/Idle. busy_o stays high from the cycle after acceptance until that last TCK pulse ends, then falls. done_o pulses for exactly one cycle as busy_o falls.
- R5: rdata_o holds the 32 TDO values sampled on the rising TCK edges of the word bits, with the first sample in bit 31. It is updated when done_o rises.
- R6: At completion, cnt_sys_o increments if the flag was 1 and cnt_dbg_o increments if it was 0. Neither counter changes at any other time except on a clear.
- R7: Each counter stops at its maximum value 2^CNT_W-1.
- R8: A cnt_clr_i pulse sets both counters to 0 in the next cycle.
- R9: A request raised while busy_o is high is ignored. The word in flight, its flag and the counter totals are unaffected.
- R10: TCK has a period of two clk cycles. TMS and TDI change only while TCK is low. TCK and TMS are low whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, accepted when not busy |
| word_i | input | 32 | Word to inject |
| sysspd_i | input | 1 | Speed flag sent ahead of the word |
| cnt_clr_i | input | 1 | Clears both counters |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Word captured from TDO |
| cnt_sys_o | output | CNT_W (16) | Words sent with flag 1 |
| cnt_dbg_o | output | CNT_W (16) | Words sent with flag 0 |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |

## Verification
The bench runs its own model of a TAP and target. That model catches several kinds of fault:
- A select path that strays into Run-Test/Idle shows up as an extra idle entry.
- A word shifted LSB first, or with the flag trailing, arrives bit-reversed or shifted by one position.
- A capture register off by one bit returns a value shifted by one position.
- Walls of all-ones, all-zero and single-end-bit words expose reversal and truncation.

Counters built with only a few bits are driven past their limit. A design that wraps there reads back small values, and one that shares a single counter mixes the two totals. A second request made in the middle of a scan would corrupt the loaded word or double-count if it were not ignored.

// File: rtl/pipe_inj_pkg.sv
package pipe_inj_pkg;
  localparam int WORD_W  = 32;
  localparam int IR_W    = 4;
  localparam int SEQ_LEN = 64;
  localparam int SEQ_W   = $clog2(SEQ_LEN);

  localparam logic [IR_W-1:0] IR_CHAIN_SEL = 4'b0010;
  localparam logic [IR_W-1:0] IR_INT_TEST  = 4'b1100;
  localparam logic [IR_W-1:0] CHAIN_NUM    = 4'b0001;

  // positions of the TCK pulses within one injection
  localparam int P_IR_A   = 4;
  localparam int P_CHAIN  = 12;
  localparam int P_IR_B   = 21;
  localparam int P_FLAG   = 29;
  localparam int P_W_FIRST = 30;
  localparam int P_W_LAST = P_W_FIRST + WORD_W - 1;
  localparam int P_END    = SEQ_LEN - 1;

  typedef struct packed {
    logic tms;
    logic tdi;
  } pin_pair_t;

  function automatic logic in_word(input logic [SEQ_W-1:0] k);
    return (int'(k) >= P_W_FIRST) && (int'(k) <= P_W_LAST);
  endfunction

  // TMS/TDI for TCK pulse k of the injection sequence
  function automatic pin_pair_t step_pins(input logic [SEQ_W-1:0] k,
                                          input logic flg,
                                          input logic [WORD_W-1:0] w);
    pin_pair_t p;
    int i;
    i = int'(k);
    p = '0;
    if (i < P_IR_A) begin
      p.tms = (i < 2);                         // to Shift-IR
    end else if (i < P_IR_A + IR_W) begin
      p.tdi = IR_CHAIN_SEL[i - P_IR_A];
      p.tms = (i == P_IR_A + IR_W - 1);
    end else if (i < P_CHAIN) begin
      p.tms = (i < P_CHAIN - 2);               // Update-IR, Select-DR, to Shift-DR
    end else if (i < P_CHAIN + IR_W) begin
      p.tdi = CHAIN_NUM[i - P_CHAIN];
      p.tms = (i == P_CHAIN + IR_W - 1);
    end else if (i < P_IR_B) begin
      p.tms = (i < P_IR_B - 2);                // Update-DR, Select-DR, Select-IR, to Shift-IR
    end else if (i < P_IR_B + IR_W) begin
      p.tdi = IR_INT_TEST[i - P_IR_B];
      p.tms = (i == P_IR_B + IR_W - 1);
    end else if (i < P_FLAG) begin
      p.tms = (i < P_FLAG - 2);
    end else if (i == P_FLAG) begin
      p.tdi = flg;
    end else if (i <= P_W_LAST) begin
      p.tdi = w[P_W_LAST - i];
      p.tms = (i == P_W_LAST);
    end else begin
      p.tms = (i != P_END);                    // Update-DR then Run-Test/Idle
    end
    return p;
  endfunction
endpackage

// File: rtl/pipe_inj_pacer.sv
module pipe_inj_pacer
  import pipe_inj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             tck,
  output logic [SEQ_W-1:0] idx,
  output logic             fire,
  output logic             fin
);
  logic last_step;

  assign last_step = (int'(idx) == P_END);
  assign fire      = busy & tck;
  assign fin       = fire & last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tck  <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      tck  <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      if (!tck) begin
        tck <= 1'b1;
      end else begin
        tck <= 1'b0;
        if (last_step) busy <= 1'b0;
        else           idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pipe_inj_capture.sv
module pipe_inj_capture
  import pipe_inj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [SEQ_W-1:0]  idx,
  input  logic              tdo,
  output logic [WORD_W-1:0] cap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cap <= '0;
    else if (fire && in_word(idx)) cap <= {cap[WORD_W-2:0], tdo};
  end
endmodule

// File: rtl/pipe_inj_satcnt.sv
module pipe_inj_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dbg_pipe_inject.sv
module dbg_pipe_inject
  import pipe_inj_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sysspd_i,
  input  logic              cnt_clr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_sys_o,
  output logic [CNT_W-1:0]  cnt_dbg_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);
  logic              start_evt;
  logic              fire_evt;
  logic              fin_evt;
  logic              busy;
  logic [SEQ_W-1:0]  idx;
  logic [WORD_W-1:0] word_q;
  logic              flag_q;
  logic [WORD_W-1:0] cap;
  pin_pair_t         pins;
  logic [1:0][CNT_W-1:0] cnt_arr;

  assign start_evt = req_i & ~busy;

  pipe_inj_pacer u_pacer (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .busy(busy),
    .tck(tck_o), .idx(idx), .fire(fire_evt), .fin(fin_evt)
  );

  pipe_inj_capture u_cap (
    .clk(clk), .rst_n(rst_n), .fire(fire_evt), .idx(idx),
    .tdo(tdo_i), .cap(cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      flag_q  <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (start_evt) begin
        word_q <= word_i;
        flag_q <= sysspd_i;
      end
      done_o <= fin_evt;
      if (fin_evt) rdata_o <= cap;
    end
  end

  always_comb pins = step_pins(idx, flag_q, word_q);

  assign tms_o  = busy & pins.tms;
  assign tdi_o  = busy & pins.tdi;
  assign busy_o = busy;

  // index 0 counts debug-speed words, index 1 system-speed words
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    pipe_inj_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(fin_evt & (flag_q == g[0])),
      .clr(cnt_clr_i), .cnt(cnt_arr[g])
    );
  end

  assign cnt_dbg_o = cnt_arr[0];
  assign cnt_sys_o = cnt_arr[1];
endmodule

// File: rtl/dbg_pipe_inject_chk.sv
module dbg_pipe_inject_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             cnt_clr_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             tck_o,
  input logic             tms_o,
  input logic             tdi_o,
  input logic [CNT_W-1:0] cnt_sys_o,
  input logic [CNT_W-1:0] cnt_dbg_o,
  input logic             fin_evt,
  input logic [31:0]      word_q
);
  // R10
  pins_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck_o) |-> $stable(tms_o) && $stable(tdi_o));
  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !tck_o && !tms_o);
  // R4
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(word_q));
  // R6
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_evt && !cnt_clr_i |=> $stable(cnt_sys_o) && $stable(cnt_dbg_o));
  // R8
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> cnt_sys_o == '0 && cnt_dbg_o == '0);
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr_i |=> cnt_sys_o >= $past(cnt_sys_o) && cnt_dbg_o >= $past(cnt_dbg_o));
endmodule

bind dbg_pipe_inject dbg_pipe_inject_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .cnt_clr_i(cnt_clr_i),
  .busy_o(busy_o), .done_o(done_o), .tck_o(tck_o), .tms_o(tms_o),
  .tdi_o(tdi_o), .cnt_sys_o(cnt_sys_o), .cnt_dbg_o(cnt_dbg_o),
  .fin_evt(fin_evt), .word_q(word_q)
);

// File: tb/dbg_pipe_inject_tb_top.sv
module dbg_pipe_inject_tb_top;
  localparam int CW   = 3;
  localparam int CMAX = (1 << CW) - 1;

  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                 S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                 S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, req, sysspd, cnt_clr;
  logic [31:0]   word;
  logic          busy, done, tck, tms, tdi;
  logic          tdo = 1'b0;
  logic [31:0]   rdata;
  logic [CW-1:0] csys, cdbg;

  int checks = 0;
  int errors = 0;
  int m_sys = 0;
  int m_dbg = 0;

  dbg_pipe_inject #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .word_i(word), .sysspd_i(sysspd),
    .cnt_clr_i(cnt_clr), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .cnt_sys_o(csys), .cnt_dbg_o(cdbg), .tck_o(tck), .tms_o(tms),
    .tdi_o(tdi), .tdo_i(tdo)
  );

  // ---------------- target TAP model ----------------
  int          st = S_RTI;
  int          nsh = 0;
  int          rti_entries = 0;
  int          loads = 0;
  logic [3:0]  ir = 4'hF, ir_sh = 4'h0, chain = 4'h0, ch_sh = 4'h0;
  logic [32:0] dr_log = '0;
  logic [31:0] got_word = '0, resp = '0;
  logic        got_flag = 1'b0;

  function automatic int tap_next(int s, logic m);
    case (s)
      S_TLR:  return m ? S_TLR  : S_RTI;
      S_RTI:  return m ? S_SDR  : S_RTI;
      S_SDR:  return m ? S_SIR  : S_CDR;
      S_CDR:  return m ? S_E1DR : S_SHDR;
      S_SHDR: return m ? S_E1DR : S_SHDR;
      S_E1DR: return m ? S_UDR  : S_PDR;
      S_PDR:  return m ? S_E2DR : S_PDR;
      S_E2DR: return m ? S_UDR  : S_SHDR;
      S_UDR:  return m ? S_SDR  : S_RTI;
      S_SIR:  return m ? S_TLR  : S_CIR;
      S_CIR:  return m ? S_E1IR : S_SHIR;
      S_SHIR: return m ? S_E1IR : S_SHIR;
      S_E1IR: return m ? S_UIR  : S_PIR;
      S_PIR:  return m ? S_E2IR : S_PIR;
      S_E2IR: return m ? S_UIR  : S_SHIR;
      default: return m ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic logic tdo_bit(int n, logic [31:0] r);
    if (n <= 0 || n > 32) return 1'b0;
    return r[32 - n];
  endfunction

  function automatic int sat(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  always @(posedge tck) begin
    int nx;
    nx = tap_next(st, tms);
    if (st == S_SHIR) ir_sh = {tdi, ir_sh[3:1]};
    if (st == S_SHDR) begin
      if (ir == 4'b0010) ch_sh = {tdi, ch_sh[3:1]};
      else if (ir == 4'b1100 && chain == 4'd1) dr_log = {dr_log[31:0], tdi};
      nsh++;
    end
    if (st == S_CDR && nx == S_SHDR) nsh = 0;
    if (nx == S_UIR) ir = ir_sh;
    if (nx == S_UDR) begin
      if (ir == 4'b0010) chain = ch_sh;
      else if (ir == 4'b1100 && chain == 4'd1) begin
        got_flag = dr_log[32];
        got_word = dr_log[31:0];
        loads++;
      end
    end
    if (nx == S_RTI && st != S_RTI) rti_entries++;
    st = nx;
  end

  always @(negedge tck) begin
    tdo = (st == S_SHDR && ir == 4'b1100 && chain == 4'd1) ? tdo_bit(nsh, resp) : 1'b0;
  end

  // ---------------- checking ----------------
  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic f, input logic [31:0] r,
                     input logic intrude);
    int rti0, ld0, n;
    resp = r;
    rti0 = rti_entries;
    ld0  = loads;
    @(negedge clk);
    req = 1'b1; word = w; sysspd = f;
    @(negedge clk);
    req = 1'b0; word = ~w; sysspd = ~f;
    chk(busy == 1'b1, "R4 busy after accept", {31'd0, busy}, 32'd1);
    if (intrude) begin
      repeat (20) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n < 400, "R4 done timeout", n, 400);
    if (f) m_sys = sat(m_sys);
    else   m_dbg = sat(m_dbg);
    chk(rdata == r, "R5 captured word", rdata, r);
    chk(got_word == w, intrude ? "R9 word kept while busy" : "R3 word order", got_word, w);
    chk(got_flag == f, "R3 leading flag", {31'd0, got_flag}, {31'd0, f});
    chk(st == S_RTI, "R4 ends in idle", st, S_RTI);
    chk(rti_entries - rti0 == 1, "R2 single idle entry", rti_entries - rti0, 1);
    chk(loads - ld0 == 1, intrude ? "R9 one load" : "R4 one update", loads - ld0, 1);
    chk(ir == 4'b1100 && chain == 4'd1, "R2 ir/chain", {24'd0, ir, chain}, 32'h000000C1);
    chk(busy == 1'b0, "R4 busy low at done", {31'd0, busy}, 32'd0);
    chk(int'(csys) == m_sys, "R6 R7 sys count", csys, m_sys);
    chk(int'(cdbg) == m_dbg, "R6 R7 dbg count", cdbg, m_dbg);
    @(negedge clk);
    chk(done == 1'b0, "R4 done one cycle", {31'd0, done}, 32'd0);
    chk(tck == 1'b0 && tms == 1'b0, "R10 idle lines", {30'd0, tck, tms}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1f3a;
    void'($urandom(seed));
    rst_n = 1'b0; req = 1'b0; word = '0; sysspd = 1'b0; cnt_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && tck == 0 && tms == 0 && tdi == 0,
        "R1 reset lines", {27'd0, busy, done, tck, tms, tdi}, 32'd0);
    chk(rdata == 0 && csys == 0 && cdbg == 0, "R1 reset values", rdata, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(32'h0000_0000, 1'b0, 32'hFFFF_FFFF, 1'b0);
    run(32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0);
    run(32'h8000_0001, 1'b0, 32'h8000_0001, 1'b0);
    run(32'hA5C3_0F96, 1'b1, 32'h1234_5678, 1'b1);
    for (int i = 0; i < 16; i++)
      run($urandom, 1'($urandom), $urandom, 1'(i % 5 == 0));

    @(negedge clk);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    m_sys = 0; m_dbg = 0;
    chk(csys == 0 && cdbg == 0, "R8 clear", {csys, cdbg}, 32'd0);

    for (int i = 0; i < CMAX + 2; i++)
      run($urandom, 1'b1, $urandom, 1'b0);
    chk(int'(csys) == CMAX, "R7 saturated", csys, CMAX);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule